// File: doc/BRIEF.md
# Interleaved Cache-Block Fill Engine

This block sits on the memory side of a cache and fetches one whole cache block from a set of independent memory banks. Consecutive words of memory are spread across the banks by their low address bits. Word `k` of a block lives in bank `k`, and the block address picks the same row in every bank. When a fill request is accepted, the block address is sent to all banks at once. Every bank then runs its access at the same time as the others. After that the words leave on a single data port, one per transfer slot, with a valid strobe, a word index and a final-word flag.

The banks are behavioural: each is a small synchronous array that has its own access countdown. Address, access and transfer times are parameters, so a fill always takes address + access + banks × transfer cycles. With the default values that is 1 + 6 + 4 = 11 cycles, where a serial fetch of four words would take 32. A word-wide load port lets the surrounding logic or the bench write the arrays before fills are issued.

Top module: `ilv_block_fetch`

## Requirements
- R1: After reset, `req_ready` is 1 and `out_valid` and `out_last` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` stays 0 until the cycle after the final word, so a request held while a fill is in progress is not taken.
- R3: A load with word address `w` writes bank `w mod NBANK` at row `w div NBANK`. For block `b`, the word returned with index `k` is the value last loaded at word address `b*NBANK + k`.
- R4: Words of a fill come out in bank order. `out_idx` takes the values 0, 1, … NBANK-1 on successive strobes, and `out_last` is 1 only together with the strobe whose index is NBANK-1.
- R5: With acceptance at edge 0 and cycle n lying between edges n-1 and n, the word with index k is strobed in cycle T_ADDR + T_ACC + (k+1)*T_XFER only. `out_valid` is a single-cycle strobe per word, and the whole fill takes T_ADDR + T_ACC + NBANK*T_XFER cycles (11 with defaults).
- R6: `req_ready` returns to 1 in the cycle after the final word. A request already waiting there is taken at the end of that cycle, and it has the same latency as a request that finds the block idle.
- R7: The address goes out to all banks once per fill. No bank is started while its previous access is still running, and every bank holds its word before the first transfer slot begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one word into the bank arrays |
| ld_waddr | input | ROW_AW+log2(NBANK) | Word address of the load; the low bits select the bank |
| ld_data | input | WORD_W | Word to load |
| req_valid | input | 1 | Fill request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_blk | input | ROW_AW | Block address of the request |
| out_valid | output | 1 | Strobe: a block word is on `out_data` |
| out_data | output | WORD_W | Returned word |
| out_idx | output | log2(NBANK) | Index of the returned word within the block |
| out_last | output | 1 | Marks the final word of the block |

## Verification
The assertions assume the requester leaves the load port alone while a fill is in progress, since a load into a row being read would change what is returned. They also assume `req_blk` is held steady from the cycle `req_valid` rises until acceptance. The bench writes all arrays only while the block is idle. It changes the block address only in the cycle after a request has been accepted, and it runs back-to-back fills by keeping `req_valid` high across the busy window, so that the waiting request is never taken early.

// File: rtl/ibf_pkg.sv
package ibf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_ACC  = 2'd2,
    PH_XFER = 2'd3
  } fill_phase_e;

  // Cycle, counted from the acceptance edge, in which word k is strobed.
  function automatic int word_slot(input int k, input int t_addr,
                                   input int t_acc, input int t_xfer);
    return t_addr + t_acc + (k + 1) * t_xfer;
  endfunction

  // Total length of one fill in cycles.
  function automatic int fill_len(input int nbank, input int t_addr,
                                  input int t_acc, input int t_xfer);
    return t_addr + t_acc + nbank * t_xfer;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ibf_bank.sv
module ibf_bank #(
  parameter int WORD_W = 16,
  parameter int ROW_AW = 4,
  parameter int T_ACC  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_AW-1:0] wr_row,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  input  logic [ROW_AW-1:0] row,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata
);
  localparam int ROWS  = 1 << ROW_AW;
  localparam int REM_W = $clog2(T_ACC + 1);

  logic [WORD_W-1:0] cells [ROWS];
  logic [ROW_AW-1:0] row_q;
  logic [REM_W-1:0]  remain;
  logic              last_tick;

  assign busy      = (remain != '0);
  assign last_tick = (remain == REM_W'(1));

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_row] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      remain <= '0;
      done   <= 1'b0;
      rdata  <= '0;
    end else if (start) begin
      row_q  <= row;
      remain <= REM_W'(T_ACC);
      done   <= 1'b0;
    end else if (busy) begin
      remain <= remain - REM_W'(1);
      if (last_tick) begin
        rdata <= cells[row_q];
        done  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ibf_seq.sv
module ibf_seq
  import ibf_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ROW_AW = 4,
  parameter int T_ADDR = 1,
  parameter int T_ACC  = 6,
  parameter int T_XFER = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ROW_AW-1:0]        req_blk,
  output logic                     bank_go,
  output logic [ROW_AW-1:0]        bank_row,
  output logic                     xfer_begin,
  output logic                     slot_end,
  output logic [$clog2(NBANK)-1:0] widx,
  output logic                     word_last
);
  localparam int IDX_W = $clog2(NBANK);
  localparam int CNT_W = $clog2(max3(T_ADDR, T_ACC, T_XFER) + 1);

  fill_phase_e       phase;
  logic [CNT_W-1:0]  cnt;
  logic [ROW_AW-1:0] blk_q;
  logic              cnt_zero;
  logic              accept;
  logic              at_final;

  assign cnt_zero   = (cnt == '0);
  assign req_ready  = (phase == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign bank_go    = (phase == PH_ADDR) && cnt_zero;
  assign bank_row   = blk_q;
  assign xfer_begin = (phase == PH_ACC) && cnt_zero;
  assign slot_end   = (phase == PH_XFER) && cnt_zero;
  assign at_final   = (widx == IDX_W'(NBANK - 1));
  assign word_last  = slot_end && at_final;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      blk_q <= '0;
      widx  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            blk_q <= req_blk;
            cnt   <= CNT_W'(T_ADDR - 1);
            phase <= PH_ADDR;
          end
        end
        PH_ADDR: begin
          if (cnt_zero) begin
            cnt   <= CNT_W'(T_ACC - 1);
            phase <= PH_ACC;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_ACC: begin
          if (cnt_zero) begin
            cnt   <= CNT_W'(T_XFER - 1);
            widx  <= '0;
            phase <= PH_XFER;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_XFER: begin
          if (cnt_zero) begin
            if (at_final) begin
              phase <= PH_IDLE;
            end else begin
              widx <= widx + IDX_W'(1);
              cnt  <= CNT_W'(T_XFER - 1);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ilv_block_fetch.sv
module ilv_block_fetch #(
  parameter int WORD_W = 16,
  parameter int NBANK  = 4,
  parameter int ROW_AW = 4,
  parameter int T_ADDR = 1,
  parameter int T_ACC  = 6,
  parameter int T_XFER = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld_en,
  input  logic [ROW_AW+$clog2(NBANK)-1:0] ld_waddr,
  input  logic [WORD_W-1:0]               ld_data,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [ROW_AW-1:0]               req_blk,
  output logic                            out_valid,
  output logic [WORD_W-1:0]               out_data,
  output logic [$clog2(NBANK)-1:0]        out_idx,
  output logic                            out_last
);
  localparam int IDX_W = $clog2(NBANK);

  logic [ROW_AW-1:0] ld_row;
  logic [IDX_W-1:0]  ld_sel;
  logic              bank_go;
  logic [ROW_AW-1:0] bank_row;
  logic              xfer_begin;
  logic              slot_end;
  logic              word_last;
  logic [IDX_W-1:0]  widx;
  logic [NBANK-1:0]  bank_start;
  logic [NBANK-1:0]  bank_busy;
  logic [NBANK-1:0]  bank_done;
  logic [WORD_W-1:0] bank_word [NBANK];

  assign ld_sel = ld_waddr[IDX_W-1:0];
  assign ld_row = ld_waddr[ROW_AW+IDX_W-1:IDX_W];

  ibf_seq #(
    .NBANK (NBANK),
    .ROW_AW(ROW_AW),
    .T_ADDR(T_ADDR),
    .T_ACC (T_ACC),
    .T_XFER(T_XFER)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_blk   (req_blk),
    .bank_go   (bank_go),
    .bank_row  (bank_row),
    .xfer_begin(xfer_begin),
    .slot_end  (slot_end),
    .widx      (widx),
    .word_last (word_last)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bank_start[g] = bank_go;
    ibf_bank #(
      .WORD_W(WORD_W),
      .ROW_AW(ROW_AW),
      .T_ACC (T_ACC)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ld_en && (ld_sel == IDX_W'(g))),
      .wr_row (ld_row),
      .wr_data(ld_data),
      .start  (bank_start[g]),
      .row    (bank_row),
      .busy   (bank_busy[g]),
      .done   (bank_done[g]),
      .rdata  (bank_word[g])
    );
  end

  assign out_valid = slot_end;
  assign out_last  = word_last;
  assign out_idx   = widx;
  assign out_data  = bank_word[widx];

endmodule

// File: rtl/ibf_checker.sv
module ibf_checker
  import ibf_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int T_ADDR = 1,
  parameter int T_ACC  = 6,
  parameter int T_XFER = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     out_valid,
  input logic [$clog2(NBANK)-1:0] out_idx,
  input logic                     out_last,
  input logic                     xfer_begin,
  input logic [NBANK-1:0]         bank_start,
  input logic [NBANK-1:0]         bank_busy,
  input logic [NBANK-1:0]         bank_done
);
  localparam int IDX_W = $clog2(NBANK);

  logic [15:0]      since_acc;
  logic [IDX_W-1:0] exp_idx;
  logic [15:0]      due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_acc <= '0;
      exp_idx   <= '0;
    end else begin
      if (req_valid && req_ready) since_acc <= 16'd1;
      else if (since_acc != '0 && since_acc != 16'hFFFF) since_acc <= since_acc + 16'd1;
      if (out_valid) exp_idx <= out_last ? '0 : exp_idx + IDX_W'(1);
    end
  end

  assign due = 16'(word_slot(int'(out_idx), T_ADDR, T_ACC, T_XFER));

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !out_last) |=> !req_ready);

  a_r4_bank_order: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx == exp_idx));

  a_r4_last_final: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_idx == IDX_W'(NBANK - 1)));

  a_r4_final_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx == IDX_W'(NBANK - 1)) |-> out_last);

  a_r5_word_slot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_acc == due));

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && T_XFER > 1) |=> !out_valid);

  a_r6_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> req_ready);

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_start & bank_busy) == '0);

  a_r7_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_start == '0) || (&bank_start));

  a_r7_words_ready: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_begin |=> (&bank_done));

endmodule

bind ilv_block_fetch ibf_checker #(
  .NBANK (NBANK),
  .T_ADDR(T_ADDR),
  .T_ACC (T_ACC),
  .T_XFER(T_XFER)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .out_valid (out_valid),
  .out_idx   (out_idx),
  .out_last  (out_last),
  .xfer_begin(xfer_begin),
  .bank_start(bank_start),
  .bank_busy (bank_busy),
  .bank_done (bank_done)
);

// File: tb/sim_ilv_block_fetch.sv
`timescale 1ns/1ps
module sim_ilv_block_fetch;
  localparam int WORD_W = 16;
  localparam int NBANK  = 4;
  localparam int ROW_AW = 4;
  localparam int T_ADDR = 1;
  localparam int T_ACC  = 6;
  localparam int T_XFER = 1;
  localparam int IDX_W  = 2;
  localparam int WA_W   = ROW_AW + IDX_W;
  localparam int NBLK   = 1 << ROW_AW;
  localparam int TOTAL  = T_ADDR + T_ACC + NBANK * T_XFER;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [WA_W-1:0] ld_waddr = '0;
  logic [WORD_W-1:0] ld_data = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ROW_AW-1:0] req_blk = '0;
  logic out_valid;
  logic [WORD_W-1:0] out_data;
  logic [IDX_W-1:0] out_idx;
  logic out_last;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ilv_block_fetch #(
    .WORD_W(WORD_W), .NBANK(NBANK), .ROW_AW(ROW_AW),
    .T_ADDR(T_ADDR), .T_ACC(T_ACC), .T_XFER(T_XFER)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_waddr(ld_waddr),
    .ld_data(ld_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_blk(req_blk), .out_valid(out_valid), .out_data(out_data),
    .out_idx(out_idx), .out_last(out_last)
  );

  function automatic logic [WORD_W-1:0] pat(input int w, input int sel);
    logic [WORD_W-1:0] v;
    v = WORD_W'(w * 37 + 16'h05A3);
    return (sel != 0) ? ~v : v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_all(input int sel);
    for (int w = 0; w < NBLK * NBANK; w++) begin
      @(negedge clk);
      ld_en = 1'b1;
      ld_waddr = WA_W'(w);
      ld_data = pat(w, sel);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Caller has req_valid=1 and req_blk=b, block idle at next edge.
  task automatic run_fill(input int b, input int sel, input bit chain, input int nb);
    int seen;
    seen = 0;
    @(posedge clk);
    for (int n = 1; n <= TOTAL + 1; n++) begin
      int rel;
      bit exp_v;
      int k;
      @(negedge clk);
      rel = n - T_ADDR - T_ACC;
      exp_v = (rel > 0) && (rel % T_XFER == 0) && (rel / T_XFER <= NBANK);
      k = exp_v ? rel / T_XFER - 1 : 0;
      if (n <= TOTAL)
        chk(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
      else
        chk(req_ready == 1'b1, "R6", "ready back after last word", req_ready, 1);
      if (exp_v || out_valid)
        chk(out_valid == exp_v, "R5", "strobe cycle", out_valid, exp_v);
      if (exp_v && out_valid) begin
        seen++;
        chk(out_idx == IDX_W'(k), "R4", "word order", out_idx, k);
        chk(out_last == (k == NBANK - 1), "R4", "last flag", out_last, k == NBANK - 1);
        chk(out_data == pat(b * NBANK + k, sel), "R3", "interleaved word",
            out_data, pat(b * NBANK + k, sel));
      end else if (!exp_v) begin
        chk(out_last == 1'b0, "R4", "no stray last", out_last, 0);
      end
      if (n == 1) begin
        if (chain) req_blk = ROW_AW'(nb);
        else req_valid = 1'b0;
      end
    end
    chk(seen == NBANK, "R5", "words per fill", seen, NBANK);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(out_valid == 1'b0, "R1", "no strobe in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && out_valid == 1'b0 && out_last == 1'b0, "R1",
        "idle after reset", {req_ready, out_valid, out_last}, 3'b100);

    // Single fills over every block, first pattern (R3, R4, R5)
    load_all(0);
    for (int b = 0; b < NBLK; b++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_blk = ROW_AW'(b);
      run_fill(b, 0, 1'b0, 0);
    end

    // Back-to-back fills with request held during busy (R2, R6, R7)
    load_all(1);
    @(negedge clk);
    req_valid = 1'b1;
    req_blk = ROW_AW'(NBLK - 1);
    for (int b = NBLK - 1; b >= 0; b--) begin
      run_fill(b, 1, b != 0, b - 1);
    end

    // Rewrite one bank row while idle, refetch (R3)
    @(negedge clk);
    ld_en = 1'b1;
    ld_waddr = WA_W'(5 * NBANK + 2);
    ld_data = 16'hBEEF;
    @(negedge clk);
    ld_en = 1'b0;
    req_valid = 1'b1;
    req_blk = ROW_AW'(5);
    @(posedge clk);
    for (int n = 1; n <= TOTAL; n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      if (n == T_ADDR + T_ACC + 3 * T_XFER)
        chk(out_valid && out_idx == 2'd2 && out_data == 16'hBEEF, "R3",
            "rewritten word from bank 2", out_data, 16'hBEEF);
      if (n == T_ADDR + T_ACC + 2 * T_XFER)
        chk(out_data == pat(5 * NBANK + 1, 1), "R3", "neighbour bank unchanged",
            out_data, pat(5 * NBANK + 1, 1));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule